// File: doc/BRIEF.md
# SDIO Read-Wait Signalling Controller

This block is the read-wait portion of an SD I/O host data path. During a multi-block read it lets the host pause the card. It has two ways of doing so. In the first, it pulls the DAT2 line low and later ends the pause with a short high pulse on DAT2. In the second, it asks the clock generator to stop the SD clock. All timing is counted in SD clock periods. A period is marked by a one-system-clock strobe, `sdclk_en`. The block never changes its counters on system clocks that do not carry that strobe.

The host sets a start bit to request a pause. The block then holds the request until the card bus is free: entry never happens while a block, including its CRC, is still arriving. Once the pause is requested, the host sets a stop bit to end it. After the stop, a new pause cannot begin until software has cleared the stop bit. While the pause is active, the block watches DAT1 for a card interrupt. It keeps any interrupt it sees in a sticky flag until software clears it.

Top module: `sdio_rdwait_ctrl`

## Requirements
- R1: A DAT2-method pause begins only when all of these hold: `path_en`=1, `sdio_mode`=1, `rw_start`=1, `clkstop_sel`=0, `dir_rx`=1 (card to host) and `rw_stop`=0. If any one is missing, DAT2 is not driven and no clock stop is requested.
- R2: After entry, `dat2_oe`=1 with `dat2_out`=0 appears on the second `sdclk_en` strobe, and not before it. System clocks without a strobe do not advance the count.
- R3: A `rw_stop`=1 sampled on a strobe while DAT2 is held low keeps DAT2 low for that strobe and for one more strobe. On the next strobe after that, DAT2 is driven high (`dat2_oe`=1, `dat2_out`=1) for exactly one strobe period. After that, `dat2_oe`=0.
- R4: After a stop, the block stays released while `rw_stop` remains 1, even with `rw_start` still held. Once `rw_stop` returns to 0, a new pause may begin.
- R5: While `blk_busy`=1 (a block or its CRC is arriving), entry is held off. Entry happens on the first system clock after `blk_busy` falls.
- R6: With `clkstop_sel`=1, a pause raises `clk_stop_req` and never drives DAT2. `rw_stop`=1 lowers `clk_stop_req` on the next system clock.
- R7: During the pause, from entry until the DAT2 high pulse, a low `dat1_in` sampled on a strobe sets `irq_flag`. A low `dat1_in` outside the pause, or on a system clock without a strobe, is ignored. The flag stays set until an `irq_clr` pulse.
- R8: `path_en`=0 returns the block to idle on the next system clock, with `dat2_oe`=0 and `clk_stop_req`=0.
- R9: After reset, `dat2_oe`=0, `clk_stop_req`=0 and `irq_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdclk_en | input | 1 | One-cycle strobe per SD clock period |
| path_en | input | 1 | Data path enable |
| sdio_mode | input | 1 | SD I/O operation enable |
| rw_start | input | 1 | Read-wait request |
| rw_stop | input | 1 | Read-wait release |
| clkstop_sel | input | 1 | 1: pause by stopping SD clock, 0: pause with DAT2 |
| dir_rx | input | 1 | 1: transfer direction card to host |
| blk_busy | input | 1 | A data block or its CRC is being received |
| dat1_in | input | 1 | Sampled DAT1 line |
| irq_clr | input | 1 | Write-one pulse clearing the interrupt flag |
| dat2_oe | output | 1 | DAT2 drive enable |
| dat2_out | output | 1 | DAT2 drive value |
| clk_stop_req | output | 1 | Request to stop the SD clock |
| irq_flag | output | 1 | Sticky SD I/O interrupt flag |

## Verification
The hardest condition to reach is the release sequence. It needs a stop that is sampled on a strobe while DAT2 is already low. It also needs the stop bit to stay set long enough to test the re-arm lockout. The bench gets there by issuing every SD clock strobe by hand. It counts strobes into the low phase, raises the stop bit between strobes, and checks DAT2 after each strobe and across strobe-free gaps. It then keeps both start and stop set over several strobes before clearing stop.

// File: rtl/rw_pkg.sv
package rw_pkg;

  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] rw_cnt_t;

  typedef enum logic [2:0] {
    RW_IDLE,
    RW_PRE,
    RW_LOW,
    RW_STOPDLY,
    RW_PULSE,
    RW_RELEASED,
    RW_CLKSTOP
  } rw_state_e;

  // true on the strobe that completes a span of len SD clock periods
  function automatic logic span_last(input logic tick, input rw_cnt_t cnt,
                                     input int unsigned len);
    return tick && (cnt == rw_cnt_t'(len - 1));
  endfunction

  // states in which DAT1 interrupts are observed
  function automatic logic in_window(input rw_state_e st);
    return (st == RW_PRE) || (st == RW_LOW) || (st == RW_STOPDLY);
  endfunction

  // states in which the block drives DAT2
  function automatic logic drives_dat2(input rw_state_e st);
    return (st == RW_LOW) || (st == RW_STOPDLY) || (st == RW_PULSE);
  endfunction

endpackage

// File: rtl/rw_qualify.sv
module rw_qualify (
  input  logic path_en,
  input  logic sdio_mode,
  input  logic rw_start,
  input  logic rw_stop,
  input  logic clkstop_sel,
  input  logic dir_rx,
  input  logic blk_busy,
  output logic go_dat2,
  output logic go_clkstop
);
  logic common;

  always_comb begin
    common     = path_en && sdio_mode && rw_start && dir_rx && !rw_stop && !blk_busy;
    go_dat2    = common && !clkstop_sel;
    go_clkstop = common && clkstop_sel;
  end
endmodule

// File: rtl/rw_seq.sv
module rw_seq
  import rw_pkg::*;
#(
  parameter int unsigned PRE_TICKS   = 2,
  parameter int unsigned STOP_TICKS  = 2,
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      path_en,
  input  logic      rw_stop,
  input  logic      go_dat2,
  input  logic      go_clkstop,
  output rw_state_e state,
  output logic      ev_enter,
  output logic      ev_drive_low,
  output logic      ev_stop_seen,
  output logic      ev_release
);
  rw_state_e st, nxt;
  rw_cnt_t   cnt;

  always_comb begin
    nxt = st;
    if (!path_en) begin
      nxt = RW_IDLE;
    end else begin
      case (st)
        RW_IDLE:     if (go_dat2) nxt = RW_PRE;
                     else if (go_clkstop) nxt = RW_CLKSTOP;
        RW_PRE:      if (span_last(tick, cnt, PRE_TICKS)) nxt = RW_LOW;
        RW_LOW:      if (tick && rw_stop) nxt = RW_STOPDLY;
        RW_STOPDLY:  if (span_last(tick, cnt, STOP_TICKS)) nxt = RW_PULSE;
        RW_PULSE:    if (span_last(tick, cnt, PULSE_TICKS)) nxt = RW_RELEASED;
        RW_RELEASED: if (!rw_stop) nxt = RW_IDLE;
        RW_CLKSTOP:  if (rw_stop) nxt = RW_RELEASED;
        default:     nxt = RW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RW_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st)  cnt <= '0;
      else if (tick)  cnt <= rw_cnt_t'(cnt + 1'b1);
    end
  end

  always_comb begin
    state        = st;
    ev_enter     = (st == RW_IDLE) && ((nxt == RW_PRE) || (nxt == RW_CLKSTOP));
    ev_drive_low = (st == RW_PRE) && (nxt == RW_LOW);
    ev_stop_seen = (st == RW_LOW) && (nxt == RW_STOPDLY);
    ev_release   = (st == RW_PULSE) && (nxt == RW_RELEASED);
  end
endmodule

// File: rtl/rw_irq.sv
module rw_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic window,
  input  logic dat1_in,
  input  logic irq_clr,
  output logic irq_flag,
  output logic ev_irq_hit
);
  always_comb ev_irq_hit = tick && window && !dat1_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_flag <= 1'b0;
    else if (ev_irq_hit) irq_flag <= 1'b1;
    else if (irq_clr)    irq_flag <= 1'b0;
  end
endmodule

// File: rtl/sdio_rdwait_ctrl.sv
module sdio_rdwait_ctrl
  import rw_pkg::*;
#(
  parameter int unsigned PRE_TICKS   = 2,
  parameter int unsigned STOP_TICKS  = 2,
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdclk_en,
  input  logic path_en,
  input  logic sdio_mode,
  input  logic rw_start,
  input  logic rw_stop,
  input  logic clkstop_sel,
  input  logic dir_rx,
  input  logic blk_busy,
  input  logic dat1_in,
  input  logic irq_clr,
  output logic dat2_oe,
  output logic dat2_out,
  output logic clk_stop_req,
  output logic irq_flag
);
  logic      go_dat2, go_clkstop;
  rw_state_e state;
  logic      ev_enter, ev_drive_low, ev_stop_seen, ev_release, ev_irq_hit;
  logic      window;

  rw_qualify u_qual (
    .path_en(path_en), .sdio_mode(sdio_mode), .rw_start(rw_start),
    .rw_stop(rw_stop), .clkstop_sel(clkstop_sel), .dir_rx(dir_rx),
    .blk_busy(blk_busy), .go_dat2(go_dat2), .go_clkstop(go_clkstop)
  );

  rw_seq #(
    .PRE_TICKS(PRE_TICKS), .STOP_TICKS(STOP_TICKS), .PULSE_TICKS(PULSE_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(sdclk_en), .path_en(path_en),
    .rw_stop(rw_stop), .go_dat2(go_dat2), .go_clkstop(go_clkstop),
    .state(state), .ev_enter(ev_enter), .ev_drive_low(ev_drive_low),
    .ev_stop_seen(ev_stop_seen), .ev_release(ev_release)
  );

  always_comb begin
    window       = in_window(state);
    dat2_oe      = drives_dat2(state);
    dat2_out     = (state == RW_PULSE);
    clk_stop_req = (state == RW_CLKSTOP);
  end

  rw_irq u_irq (
    .clk(clk), .rst_n(rst_n), .tick(sdclk_en), .window(window),
    .dat1_in(dat1_in), .irq_clr(irq_clr), .irq_flag(irq_flag),
    .ev_irq_hit(ev_irq_hit)
  );
endmodule

// File: rtl/sdio_rdwait_ctrl_chk.sv
module sdio_rdwait_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sdclk_en,
  input logic path_en,
  input logic rw_stop,
  input logic blk_busy,
  input logic irq_clr,
  input logic dat2_oe,
  input logic dat2_out,
  input logic clk_stop_req,
  input logic irq_flag,
  input logic ev_enter,
  input logic ev_drive_low,
  input logic ev_stop_seen,
  input logic ev_release,
  input logic ev_irq_hit
);
  // R8
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en |=> (!dat2_oe && !clk_stop_req));

  // R5
  enter_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter |-> !blk_busy);

  // R4
  enter_stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter |-> !rw_stop);

  // R2
  low_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drive_low |=> (dat2_oe && !dat2_out));

  // R3
  stop_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_seen |-> (sdclk_en && rw_stop));

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat2_oe && dat2_out && sdclk_en) |=> !(dat2_oe && dat2_out));

  // R3
  released_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> !dat2_oe);

  // R6
  method_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat2_oe && clk_stop_req));

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_hit |=> irq_flag);
endmodule

bind sdio_rdwait_ctrl sdio_rdwait_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdclk_en(sdclk_en), .path_en(path_en),
  .rw_stop(rw_stop), .blk_busy(blk_busy), .irq_clr(irq_clr),
  .dat2_oe(dat2_oe), .dat2_out(dat2_out), .clk_stop_req(clk_stop_req),
  .irq_flag(irq_flag), .ev_enter(ev_enter), .ev_drive_low(ev_drive_low),
  .ev_stop_seen(ev_stop_seen), .ev_release(ev_release), .ev_irq_hit(ev_irq_hit)
);

// File: tb/sdio_rdwait_ctrl_bench.sv
module sdio_rdwait_ctrl_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic sdclk_en, path_en, sdio_mode, rw_start, rw_stop, clkstop_sel;
  logic dir_rx, blk_busy, dat1_in, irq_clr;
  logic dat2_oe, dat2_out, clk_stop_req, irq_flag;
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;

  always #(CLK_P/2) clk = ~clk;

  sdio_rdwait_ctrl u_sdio_rdwait_ctrl (
    .clk(clk), .rst_n(rst_n), .sdclk_en(sdclk_en), .path_en(path_en),
    .sdio_mode(sdio_mode), .rw_start(rw_start), .rw_stop(rw_stop),
    .clkstop_sel(clkstop_sel), .dir_rx(dir_rx), .blk_busy(blk_busy),
    .dat1_in(dat1_in), .irq_clr(irq_clr), .dat2_oe(dat2_oe),
    .dat2_out(dat2_out), .clk_stop_req(clk_stop_req), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // expected DAT2 line: {oe, value}
  task automatic chk_dat2(input string req, input logic oe, input logic val);
    chk(req, "dat2_oe", dat2_oe, oe);
    if (oe) chk(req, "dat2_out", dat2_out, val);
  endtask

  task automatic strobe();
    @(negedge clk) sdclk_en = 1'b1;
    @(negedge clk) sdclk_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic defaults();
    sdclk_en = 0; sdio_mode = 1; rw_start = 0; rw_stop = 0; clkstop_sel = 0;
    dir_rx = 1; blk_busy = 0; dat1_in = 1; irq_clr = 0;
  endtask

  task automatic to_idle();
    @(negedge clk) path_en = 0;
    wait_clk(2);
    defaults();
    path_en = 1;
    wait_clk(1);
  endtask

  task automatic t_reset();
    chk("R9", "dat2_oe", dat2_oe, 1'b0);
    chk("R9", "clk_stop_req", clk_stop_req, 1'b0);
    chk("R9", "irq_flag", irq_flag, 1'b0);
  endtask

  task automatic t_entry_gate();
    for (int k = 0; k < 5; k++) begin
      to_idle();
      rw_start = 1;
      case (k)
        0: sdio_mode = 0;
        1: dir_rx = 0;
        2: path_en = 0;
        3: rw_stop = 1;
        default: rw_start = 0;
      endcase
      strobe(); strobe(); strobe();
      chk("R1", $sformatf("gate%0d dat2_oe", k), dat2_oe, 1'b0);
      chk("R1", $sformatf("gate%0d clk_stop_req", k), clk_stop_req, 1'b0);
    end
    to_idle();
  endtask

  // R2 and R3: entry timing, stop timing, single high pulse
  task automatic t_timing();
    to_idle();
    rw_start = 1;
    wait_clk(1);
    chk_dat2("R2", 1'b0, 1'b0);
    strobe();
    chk_dat2("R2", 1'b0, 1'b0);
    wait_clk(4);
    chk_dat2("R2", 1'b0, 1'b0);
    strobe();
    chk_dat2("R2", 1'b1, 1'b0);
    wait_clk(3);
    chk_dat2("R2", 1'b1, 1'b0);
    strobe();
    chk_dat2("R3", 1'b1, 1'b0);
    rw_stop = 1;
    strobe();
    chk_dat2("R3", 1'b1, 1'b0);
    strobe();
    chk_dat2("R3", 1'b1, 1'b0);
    strobe();
    chk_dat2("R3", 1'b1, 1'b1);
    wait_clk(3);
    chk_dat2("R3", 1'b1, 1'b1);
    strobe();
    chk_dat2("R3", 1'b0, 1'b0);
  endtask

  // R4: continues from the released state of t_timing
  task automatic t_rearm();
    strobe(); strobe(); strobe();
    chk_dat2("R4", 1'b0, 1'b0);
    rw_stop = 0;
    wait_clk(2);
    strobe(); strobe();
    chk_dat2("R4", 1'b1, 1'b0);
    to_idle();
  endtask

  task automatic t_defer();
    blk_busy = 1; rw_start = 1;
    strobe(); strobe(); strobe();
    chk_dat2("R5", 1'b0, 1'b0);
    blk_busy = 0;
    wait_clk(1);
    strobe();
    chk_dat2("R5", 1'b0, 1'b0);
    strobe();
    chk_dat2("R5", 1'b1, 1'b0);
    to_idle();
  endtask

  task automatic t_clkstop();
    clkstop_sel = 1; rw_start = 1;
    wait_clk(1);
    chk("R6", "clk_stop_req", clk_stop_req, 1'b1);
    strobe(); strobe(); strobe();
    chk("R6", "clk_stop_req held", clk_stop_req, 1'b1);
    chk("R6", "dat2_oe", dat2_oe, 1'b0);
    rw_stop = 1;
    wait_clk(1);
    chk("R6", "clk_stop_req after stop", clk_stop_req, 1'b0);
    to_idle();
  endtask

  task automatic t_irq();
    dat1_in = 0;
    strobe();
    chk("R7", "irq outside pause", irq_flag, 1'b0);
    dat1_in = 1;
    rw_start = 1;
    wait_clk(1);
    dat1_in = 0;
    wait_clk(3);
    chk("R7", "irq without strobe", irq_flag, 1'b0);
    strobe();
    chk("R7", "irq set", irq_flag, 1'b1);
    dat1_in = 1;
    strobe(); strobe();
    chk("R7", "irq sticky", irq_flag, 1'b1);
    irq_clr = 1;
    wait_clk(1);
    irq_clr = 0;
    chk("R7", "irq cleared", irq_flag, 1'b0);
    to_idle();
  endtask

  task automatic t_disable();
    rw_start = 1;
    wait_clk(1);
    strobe(); strobe();
    chk_dat2("R8", 1'b1, 1'b0);
    path_en = 0;
    wait_clk(1);
    chk("R8", "dat2_oe after disable", dat2_oe, 1'b0);
    to_idle();
    clkstop_sel = 1; rw_start = 1;
    wait_clk(1);
    path_en = 0;
    wait_clk(1);
    chk("R8", "clk_stop_req after disable", clk_stop_req, 1'b0);
    to_idle();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    defaults();
    path_en = 1;
    rst_n = 0;
    wait_clk(3);
    rst_n = 1;
    wait_clk(1);
    t_reset();
    t_entry_gate();
    t_timing();
    t_rearm();
    t_defer();
    t_clkstop();
    t_irq();
    t_disable();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule